// File: doc/BRIEF.md
# Dual-Input Power Path Arbiter

This controller decides which of two input supply ports feeds a shared power bus. Each port reaches the bus through an external back-to-back switch pair, and the block drives one gate-enable per pair. It chooses a port on its own when the first usable input appears. It moves to the other port when the active one faults. It carries out host-requested swaps with a break-before-make changeover: the old pair opens, the bus is allowed to fall below its presence threshold, and only then does the new pair close. While this happens, the downstream converter is told to pause.

The host sees a register-like write port. A write carries two path-enable bits and a global disable bit. The block reads back the enable bits it actually applied. Those bits may differ from what was written: some writes are refused, and the block rewrites the bits itself after a failover. Bit 0 of every two-bit port belongs to port 1 and bit 1 to port 2. A port counts as usable when its valid flag is high and none of its undervoltage, overvoltage or overcurrent flags is set. All outputs are registered, so each reaction shows at the ports one clock after the edge that sampled its cause.

Top module: `pwr_path_arb`

## Requirements
- R1: During and right after synchronous reset, both gates are off, the enable readback is 00, the disable readback is 0 and the pause flag is 0.
- R2: With no path active, the first port to become usable has its gate turned on, and its enable bit is set, one cycle later. No write is needed.
- R3: If both ports become usable in the same cycle while idle, port 1 is enabled (gate 01) and port 2 stays off.
- R4: A port that becomes usable while the other path is already active stays off, and the enable readback is unchanged.
- R5: A write of a one-hot enable value naming the inactive port starts a changeover, and the readback shows the new value at once. A write of 11 is ignored: gates and readback keep their previous values.
- R6: During a changeover both gates are off and the pause flag is 1, until bus_present is sampled low. The new gate turns on one cycle after that sample. Writes other than the disable bit are ignored meanwhile. The two gates are never on together.
- R7: If the active port stops being usable while the other port is usable, the block starts a changeover to the other port without any write and rewrites the enable readback to the new one-hot value. If the other port is not usable either, both gates go off and the readback becomes 00.
- R8: Writing the disable bit as 1 turns both gates off and clears the enable readback in the next cycle. Writing it back to 0 restarts automatic first-usable selection in that same cycle.
- R9: A write of 00 while only one port is usable is ignored. While both ports are usable it turns both gates off, and they stay off until a one-hot write names a usable port. That port's gate then turns on in the next cycle.
- R10: If the target port is no longer usable when a changeover ends, both gates stay off and the readback becomes 00 for one cycle, before automatic selection runs again.
- R11: In the first cycle after reset, the switch-pair presence inputs are captured into the path status outputs, which then hold that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_ok | input | 2 | Per-port input valid flag |
| flt_uv | input | 2 | Per-port undervoltage fault |
| flt_ov | input | 2 | Per-port overvoltage fault |
| flt_oc | input | 2 | Per-port overcurrent fault |
| bus_present | input | 1 | Shared bus above presence threshold |
| pair_det | input | 2 | Switch pair detected present, per port |
| wr_en | input | 1 | Host write strobe |
| wr_en_bits | input | 2 | Written path-enable bits |
| wr_dis | input | 1 | Written global disable bit |
| gate | output | 2 | Gate enable per switch pair |
| en_rb | output | 2 | Applied path-enable bits |
| dis_rb | output | 1 | Applied global disable bit |
| pair_stat | output | 2 | Captured switch pair presence status |
| conv_pause | output | 1 | Converter pause during changeover |

## Verification
Every decision lands in a registered output one edge after its cause, so a wrong internal state is visible on the gate, readback or pause pins within a single cycle. A state register stuck in changeover shows as a pause flag that stays high after the bus has collapsed. A wrong selected index shows as the wrong gate bit, or as readback and gate bits that disagree. A missing refusal shows as gates that drop after a 00 or 11 write. The scenarios therefore follow each stimulus with a check on the very next cycle, and changeovers are stretched by holding bus_present high to expose early make.

// File: rtl/pparb_pkg.sv
package pparb_pkg;
  localparam int NP = 2;
  localparam int PW = (NP > 1) ? $clog2(NP) : 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ON    = 2'd1,
    ST_DRAIN = 2'd2,
    ST_HOLD  = 2'd3
  } arb_st_e;

  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_PICK = 2'd1,
    WR_OFF  = 2'd2,
    WR_BAD  = 2'd3
  } wr_kind_e;

  function automatic logic [NP-1:0] port_mask(input logic [PW-1:0] idx);
    logic [NP-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pparb_qual.sv
module pparb_qual
  import pparb_pkg::*;
(
  input  logic [NP-1:0] ok,
  input  logic [NP-1:0] uv,
  input  logic [NP-1:0] ov,
  input  logic [NP-1:0] oc,
  output logic [NP-1:0] usable
);
  for (genvar i = 0; i < NP; i++) begin : g_port
    assign usable[i] = ok[i] & ~(uv[i] | ov[i] | oc[i]);
  end
endmodule

// File: rtl/pparb_wrfilt.sv
module pparb_wrfilt
  import pparb_pkg::*;
(
  input  logic          wr_en,
  input  logic [NP-1:0] bits,
  output wr_kind_e      kind,
  output logic [PW-1:0] pick
);
  always_comb begin
    pick = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (bits[i]) pick = PW'(i);
    end
    if (!wr_en)              kind = WR_NONE;
    else if (bits == '0)     kind = WR_OFF;
    else if ($onehot(bits))  kind = WR_PICK;
    else                     kind = WR_BAD;
  end
endmodule

// File: rtl/pparb_stat.sv
module pparb_stat
  import pparb_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] det,
  output logic [NP-1:0] stat
);
  logic done;

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      stat <= '0;
    end else if (!done) begin
      done <= 1'b1;
      stat <= det;
    end
  end
endmodule

// File: rtl/pparb_fsm.sv
module pparb_fsm
  import pparb_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] usable,
  input  logic          bus_present,
  input  logic          wr_en,
  input  logic          wr_dis,
  input  wr_kind_e      kind,
  input  logic [PW-1:0] pick,
  output logic [NP-1:0] gate,
  output logic [NP-1:0] en_q,
  output logic          dis_q,
  output logic          pause
);
  arb_st_e       st, st_n;
  logic [PW-1:0] sel, sel_n;
  logic [PW-1:0] oth;
  logic [NP-1:0] en_n;
  logic          dis_n;

  assign oth = sel ^ PW'(1);

  always_comb begin
    st_n  = st;
    sel_n = sel;
    en_n  = en_q;
    dis_n = wr_en ? wr_dis : dis_q;
    if (dis_n) begin
      st_n = ST_IDLE;
      en_n = '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (usable[0]) begin
            st_n = ST_ON; sel_n = '0; en_n = port_mask('0);
          end else if (usable[1]) begin
            st_n = ST_ON; sel_n = PW'(1); en_n = port_mask(PW'(1));
          end
        end
        ST_ON: begin
          if (!usable[sel]) begin
            if (usable[oth]) begin
              st_n = ST_DRAIN; sel_n = oth; en_n = port_mask(oth);
            end else begin
              st_n = ST_IDLE; en_n = '0;
            end
          end else if (kind == WR_OFF && (&usable)) begin
            st_n = ST_HOLD; en_n = '0;
          end else if (kind == WR_PICK && pick != sel) begin
            st_n = ST_DRAIN; sel_n = pick; en_n = port_mask(pick);
          end
        end
        ST_DRAIN: begin
          if (!bus_present) begin
            if (usable[sel]) begin
              st_n = ST_ON;
            end else begin
              st_n = ST_IDLE; en_n = '0;
            end
          end
        end
        ST_HOLD: begin
          if (kind == WR_PICK && usable[pick]) begin
            st_n = ST_ON; sel_n = pick; en_n = port_mask(pick);
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      sel   <= '0;
      en_q  <= '0;
      dis_q <= 1'b0;
      gate  <= '0;
      pause <= 1'b0;
    end else begin
      st    <= st_n;
      sel   <= sel_n;
      en_q  <= en_n;
      dis_q <= dis_n;
      gate  <= (st_n == ST_ON) ? port_mask(sel_n) : '0;
      pause <= (st_n == ST_DRAIN);
    end
  end
endmodule

// File: rtl/pwr_path_arb.sv
module pwr_path_arb
  import pparb_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] port_ok,
  input  logic [NP-1:0] flt_uv,
  input  logic [NP-1:0] flt_ov,
  input  logic [NP-1:0] flt_oc,
  input  logic          bus_present,
  input  logic [NP-1:0] pair_det,
  input  logic          wr_en,
  input  logic [NP-1:0] wr_en_bits,
  input  logic          wr_dis,
  output logic [NP-1:0] gate,
  output logic [NP-1:0] en_rb,
  output logic          dis_rb,
  output logic [NP-1:0] pair_stat,
  output logic          conv_pause
);
  logic [NP-1:0] usable;
  wr_kind_e      kind;
  logic [PW-1:0] pick;

  pparb_qual u_qual (
    .ok(port_ok), .uv(flt_uv), .ov(flt_ov), .oc(flt_oc), .usable(usable)
  );

  pparb_wrfilt u_wrf (
    .wr_en(wr_en), .bits(wr_en_bits), .kind(kind), .pick(pick)
  );

  pparb_stat u_stat (
    .clk(clk), .rst(rst), .det(pair_det), .stat(pair_stat)
  );

  pparb_fsm u_fsm (
    .clk(clk), .rst(rst), .usable(usable), .bus_present(bus_present),
    .wr_en(wr_en), .wr_dis(wr_dis), .kind(kind), .pick(pick),
    .gate(gate), .en_q(en_rb), .dis_q(dis_rb), .pause(conv_pause)
  );
endmodule

// File: rtl/pparb_chk.sv
module pparb_chk
  import pparb_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic [NP-1:0] gate,
  input logic [NP-1:0] en_rb,
  input logic          dis_rb,
  input logic          conv_pause,
  input logic          bus_present
);
  // R6: the two switch pairs are never closed together
  a_r6_one_gate: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gate));

  // R6: a paused converter sees both pairs open
  a_r6_pause_open: assert property (@(posedge clk) disable iff (rst)
    conv_pause |-> (gate == '0));

  // R6: a changeover only closes the new pair after the bus was seen low
  a_r6_make_after_break: assert property (@(posedge clk) disable iff (rst)
    ($past(conv_pause) && !conv_pause && gate != '0) |-> !$past(bus_present));

  // R8: disable keeps everything off and the readback cleared
  a_r8_dis_off: assert property (@(posedge clk) disable iff (rst)
    dis_rb |-> (gate == '0 && en_rb == '0));

  // R2: a closed pair is always reflected in the enable readback
  a_r2_gate_matches_en: assert property (@(posedge clk) disable iff (rst)
    (gate != '0) |-> (gate == en_rb));
endmodule

bind pwr_path_arb pparb_chk u_chk (
  .clk(clk), .rst(rst), .gate(gate), .en_rb(en_rb), .dis_rb(dis_rb),
  .conv_pause(conv_pause), .bus_present(bus_present)
);

// File: tb/sim_pwr_path_arb.sv
`timescale 1ns/1ps
module sim_pwr_path_arb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] vok = '0, uv = '0, ov = '0, oc = '0, pdet = 2'b01;
  logic       busp = 1'b0, wr = 1'b0, wdis = 1'b0;
  logic [1:0] wbits = '0;
  logic [1:0] gate, en_rb, pstat;
  logic       dis_rb, pause;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string      tag;
    logic [1:0] g;
    logic [1:0] e;
    logic       p;
    logic       d;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  pwr_path_arb u0 (
    .clk(clk), .rst(rst), .port_ok(vok), .flt_uv(uv), .flt_ov(ov), .flt_oc(oc),
    .bus_present(busp), .pair_det(pdet), .wr_en(wr), .wr_en_bits(wbits),
    .wr_dis(wdis), .gate(gate), .en_rb(en_rb), .dis_rb(dis_rb),
    .pair_stat(pstat), .conv_pause(pause)
  );

  task automatic go(input string tag, input logic [1:0] g, input logic [1:0] e,
                    input logic p, input logic d);
    exp_t it;
    it.tag = tag; it.g = g; it.e = e; it.p = p; it.d = d;
    sb.push_back(it);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic hw(input logic [1:0] bits, input logic dis);
    wr = 1'b1; wbits = bits; wdis = dis;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        checks++;
        if (gate !== it.g || en_rb !== it.e || pause !== it.p || dis_rb !== it.d) begin
          errors++;
          $display("FAIL %s: gate=%b en=%b pause=%b dis=%b expected gate=%b en=%b pause=%b dis=%b",
                   it.tag, gate, en_rb, pause, dis_rb, it.g, it.e, it.p, it.d);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 1'b0;
    go("R1", 2'b00, 2'b00, 1'b0, 1'b0);
    checks++;
    if (pstat !== 2'b01) begin
      errors++;
      $display("FAIL R11: pair_stat=%b expected 01", pstat);
    end
    pdet = 2'b10;
    go("R1", 2'b00, 2'b00, 1'b0, 1'b0);
    checks++;
    if (pstat !== 2'b01) begin
      errors++;
      $display("FAIL R11: pair_stat=%b expected 01 held", pstat);
    end

    // port 2 first
    vok = 2'b10;
    go("R2", 2'b10, 2'b10, 1'b0, 1'b0);
    vok = 2'b11;
    go("R4", 2'b10, 2'b10, 1'b0, 1'b0);
    // host swap to port 1, bus slow to collapse
    busp = 1'b1; hw(2'b01, 1'b0);
    go("R5", 2'b00, 2'b01, 1'b1, 1'b0);
    go("R6", 2'b00, 2'b01, 1'b1, 1'b0);
    busp = 1'b0;
    go("R6", 2'b01, 2'b01, 1'b0, 1'b0);
    hw(2'b11, 1'b0);
    go("R5", 2'b01, 2'b01, 1'b0, 1'b0);
    // 00 with both usable
    hw(2'b00, 1'b0);
    go("R9", 2'b00, 2'b00, 1'b0, 1'b0);
    go("R9", 2'b00, 2'b00, 1'b0, 1'b0);
    hw(2'b10, 1'b0);
    go("R9", 2'b10, 2'b10, 1'b0, 1'b0);
    // overcurrent failover
    busp = 1'b1; oc = 2'b10;
    go("R7", 2'b00, 2'b01, 1'b1, 1'b0);
    busp = 1'b0;
    go("R7", 2'b01, 2'b01, 1'b0, 1'b0);
    oc = 2'b00; vok = 2'b01;
    go("R4", 2'b01, 2'b01, 1'b0, 1'b0);
    hw(2'b00, 1'b0);
    go("R9", 2'b01, 2'b01, 1'b0, 1'b0);
    // disable
    hw(2'b01, 1'b1);
    go("R8", 2'b00, 2'b00, 1'b0, 1'b1);
    go("R8", 2'b00, 2'b00, 1'b0, 1'b1);
    hw(2'b00, 1'b0);
    go("R8", 2'b01, 2'b01, 1'b0, 1'b0);
    // only input lost
    uv = 2'b01;
    go("R7", 2'b00, 2'b00, 1'b0, 1'b0);
    uv = 2'b00;
    go("R2", 2'b01, 2'b01, 1'b0, 1'b0);
    // changeover target vanishes
    vok = 2'b11; busp = 1'b1; hw(2'b10, 1'b0);
    go("R5", 2'b00, 2'b10, 1'b1, 1'b0);
    vok = 2'b01; busp = 1'b0;
    go("R10", 2'b00, 2'b00, 1'b0, 1'b0);
    go("R10", 2'b01, 2'b01, 1'b0, 1'b0);
    // overvoltage failover with bus already low
    vok = 2'b11; ov = 2'b01;
    go("R7", 2'b00, 2'b10, 1'b1, 1'b0);
    go("R7", 2'b10, 2'b10, 1'b0, 1'b0);
    ov = 2'b00;
    // writes ignored during changeover
    busp = 1'b1; hw(2'b01, 1'b0);
    go("R5", 2'b00, 2'b01, 1'b1, 1'b0);
    hw(2'b10, 1'b0);
    go("R6", 2'b00, 2'b01, 1'b1, 1'b0);
    busp = 1'b0;
    go("R6", 2'b01, 2'b01, 1'b0, 1'b0);
    // tie from idle
    hw(2'b00, 1'b1);
    go("R8", 2'b00, 2'b00, 1'b0, 1'b1);
    vok = 2'b00; hw(2'b00, 1'b0);
    go("R8", 2'b00, 2'b00, 1'b0, 1'b0);
    vok = 2'b11;
    go("R3", 2'b01, 2'b01, 1'b0, 1'b0);
    go("R4", 2'b01, 2'b01, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule